// File: doc/BRIEF.md
# Speculative I/O Read Guard

This block sits in a pipelined memory unit, between the operand-decode stage and the memory bus. It takes virtual-address read requests one at a time and translates each through a small fully associative translation buffer. It then classifies the physical address as ordinary memory or device (I/O) space. Ordinary reads go to the bus at once, even while older instructions are still in flight. Device registers must never be read speculatively, because a read can have side effects.

A device-space read that arrives while the execution side reports unfinished older work is therefore thrown away. The requester receives a replay pulse. All further speculative prefetch is frozen until the execution side re-presents the read marked non-speculative. That non-speculative read goes to the bus even while the freeze is active, and its returned data ends the freeze. A flush input, raised when an older instruction faults, ends the freeze without issuing the dropped read.

Translation entries are loaded from outside through a write port, in round-robin order. A lookup that finds no entry is answered with a miss pulse and nothing goes to the bus. The refill happens elsewhere.

Top module: `io_read_guard`

## Requirements
- R1: On a hit the bus address is the frame number of the lowest-indexed valid matching entry, concatenated with the low PAGE_BITS bits of the virtual address. The page number is the upper VA_W-PAGE_BITS bits of the virtual address.
- R2: `bus_is_io` is 1 exactly when the most significant physical address bit (bit PA_W-1, bit 29 by default) is 1.
- R3: `req_ready` is high only when no request is in flight, `flush` is low, and either no freeze is active or `req_nonspec` is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R4: An accepted hit with the I/O bit set, `req_nonspec` = 0 and `older_pending` = 1 never reaches the bus. In the next cycle `rsp_replay` pulses for one cycle and `prefetch_stall` goes high.
- R5: While `prefetch_stall` is high, no request with `req_nonspec` = 0 is accepted.
- R6: Any accepted hit that is not dropped under R4 raises `bus_valid` in the next cycle, whatever the value of `older_pending`. `bus_valid` and `bus_paddr` then hold until a cycle with `bus_ready` high.
- R7: An accepted request that misses gives a one-cycle `rsp_miss` pulse in the next cycle and no bus activity.
- R8: A non-speculative I/O read is performed while the freeze is active. `prefetch_stall` drops in the same cycle that its `rsp_done` pulse appears.
- R9: After the bus transfer, the cycle following the one with `bus_rvalid` high shows a one-cycle `rsp_done` pulse, with `rsp_data` equal to the `bus_rdata` sampled on that edge.
- R10: `flush` clears `prefetch_stall` in the next cycle and issues nothing to the bus.
- R11: Each `tlb_wr_en` cycle writes page number, frame number and valid bit into the next slot in round-robin order, wrapping after ENTRIES-1. Writing with `tlb_wr_valid` = 0 removes that slot from lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | VA_W | Virtual address of the read |
| req_nonspec | input | 1 | Request is the oldest operation (non-speculative) |
| older_pending | input | 1 | Older instructions have not yet completed |
| flush | input | 1 | Older instruction faulted; abandon frozen state |
| tlb_wr_en | input | 1 | Write one translation entry |
| tlb_wr_vpn | input | VA_W-PAGE_BITS | Page number to write |
| tlb_wr_pfn | input | PA_W-PAGE_BITS | Frame number to write |
| tlb_wr_valid | input | 1 | Valid bit of the written entry |
| bus_valid | output | 1 | Bus read request |
| bus_ready | input | 1 | Bus takes the request |
| bus_paddr | output | PA_W | Physical read address |
| bus_is_io | output | 1 | Request targets device space |
| bus_rvalid | input | 1 | Read data returning |
| bus_rdata | input | DATA_W | Returned data |
| rsp_done | output | 1 | Read completed pulse |
| rsp_data | output | DATA_W | Data of the completed read |
| rsp_miss | output | 1 | Translation miss pulse |
| rsp_replay | output | 1 | I/O read dropped; replay needed |
| prefetch_stall | output | 1 | Speculative prefetch frozen |

## Verification
The bench builds the block with an 8-entry buffer, 512-byte pages, a 32-bit virtual and 30-bit physical address, and 32-bit data. With only eight slots, a dozen writes wrap the round-robin pointer, so overwrites, invalidations and a duplicate page number shadowed by a lower slot can be reached quickly. With a 30-bit physical address, the I/O flag is the frame number's top bit, and each mapping can be placed on either side of the split. A random bus ready/return pattern, together with random pending and flush inputs, drives drops, replays and freezes against the reference model on every clock.

// File: rtl/iorg_pkg.sv
package iorg_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic done;
      logic miss;
      logic replay;
   } rsp_flags_t;

endpackage

// File: rtl/iorg_xlate_buf.sv
module iorg_xlate_buf #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 23,
   parameter int PFN_W   = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PFN_W-1:0] wr_pfn,
   input  logic             wr_valid,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("iorg_xlate_buf: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1) begin : g_bad_widths
      $error("iorg_xlate_buf: page and frame widths must be positive");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [IDX_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   sel;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[e] <= 1'b0;
            vpn_q[e] <= '0;
            pfn_q[e] <= '0;
         end else if (wr_en && ptr_q == IDX_W'(e)) begin
            vld_q[e] <= wr_valid;
            vpn_q[e] <= wr_vpn;
            pfn_q[e] <= wr_pfn;
         end
      end
      assign match[e] = vld_q[e] && (vpn_q[e] == lk_vpn);
   end

   // lowest matching slot wins
   always_comb begin
      sel = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (match[k]) sel = IDX_W'(k);
      end
   end

   assign lk_hit = |match;
   assign lk_pfn = pfn_q[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_en) begin
         ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
      end
   end

   p_sel_matches_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> match[sel]);

   p_ptr_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_IDX);

   p_ptr_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ptr_q));

endmodule

// File: rtl/iorg_seq.sv
module iorg_seq
   import iorg_pkg::*;
#(
   parameter int PA_W   = 30,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_nonspec,
   input  logic              older_pending,
   input  logic              flush,
   input  logic              lk_hit,
   input  logic [PA_W-1:0]   lk_paddr,
   output logic              req_ready,
   output logic              bus_valid,
   output logic [PA_W-1:0]   bus_paddr,
   output logic              bus_is_io,
   input  logic              bus_ready,
   input  logic              bus_rvalid,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_miss,
   output logic              rsp_replay,
   output logic              prefetch_stall
);
   localparam int IO_BIT = PA_W - 1;

   if (PA_W < 2) begin : g_bad_pa
      $error("iorg_seq: PA_W must be at least 2");
   end

   seq_state_e        st_q, st_d;
   logic              stall_q, stall_d;
   logic [PA_W-1:0]   pa_q;
   logic              io_q;
   rsp_flags_t        flg_q, flg_d;
   logic [DATA_W-1:0] data_q;

   logic accept, lk_io, drop, issue, rd_done;

   assign req_ready = (st_q == SEQ_IDLE) && !flush && (!stall_q || req_nonspec);
   assign accept    = req_valid && req_ready;
   assign lk_io     = lk_paddr[IO_BIT];
   assign drop      = accept && lk_hit && lk_io && !req_nonspec && older_pending;
   assign issue     = accept && lk_hit && !drop;
   assign rd_done   = (st_q == SEQ_WAIT) && bus_rvalid;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SEQ_IDLE:  if (issue) st_d = SEQ_ISSUE;
         SEQ_ISSUE: if (bus_ready) st_d = SEQ_WAIT;
         SEQ_WAIT:  if (bus_rvalid) st_d = SEQ_IDLE;
         default:   st_d = SEQ_IDLE;
      endcase
   end

   always_comb begin
      if (flush)                stall_d = 1'b0;
      else if (drop)            stall_d = 1'b1;
      else if (rd_done && io_q) stall_d = 1'b0;
      else                      stall_d = stall_q;
   end

   always_comb begin
      flg_d.done   = rd_done;
      flg_d.miss   = accept && !lk_hit;
      flg_d.replay = drop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         stall_q <= 1'b0;
         pa_q    <= '0;
         io_q    <= 1'b0;
         flg_q   <= '0;
         data_q  <= '0;
      end else begin
         st_q    <= st_d;
         stall_q <= stall_d;
         flg_q   <= flg_d;
         if (issue) begin
            pa_q <= lk_paddr;
            io_q <= lk_io;
         end
         if (rd_done) data_q <= bus_rdata;
      end
   end

   assign bus_valid      = (st_q == SEQ_ISSUE);
   assign bus_paddr      = pa_q;
   assign bus_is_io      = io_q;
   assign rsp_done       = flg_q.done;
   assign rsp_miss       = flg_q.miss;
   assign rsp_replay     = flg_q.replay;
   assign rsp_data       = data_q;
   assign prefetch_stall = stall_q;

   p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready);

   p_drop_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_replay |-> (!bus_valid && prefetch_stall));

   p_freeze_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prefetch_stall && !req_nonspec) |-> !req_ready);

   p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_paddr)));

   p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_miss |-> !bus_valid);

   p_single_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_done, rsp_miss, rsp_replay}));

   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!prefetch_stall && !bus_valid || $past(st_q) != SEQ_IDLE));

endmodule

// File: rtl/io_read_guard.sv
module io_read_guard #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 30,
   parameter int PAGE_BITS = 9,
   parameter int ENTRIES   = 8,
   parameter int DATA_W    = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [VA_W-1:0]           req_vaddr,
   input  logic                      req_nonspec,
   input  logic                      older_pending,
   input  logic                      flush,
   input  logic                      tlb_wr_en,
   input  logic [VA_W-PAGE_BITS-1:0] tlb_wr_vpn,
   input  logic [PA_W-PAGE_BITS-1:0] tlb_wr_pfn,
   input  logic                      tlb_wr_valid,
   output logic                      bus_valid,
   input  logic                      bus_ready,
   output logic [PA_W-1:0]           bus_paddr,
   output logic                      bus_is_io,
   input  logic                      bus_rvalid,
   input  logic [DATA_W-1:0]         bus_rdata,
   output logic                      rsp_done,
   output logic [DATA_W-1:0]         rsp_data,
   output logic                      rsp_miss,
   output logic                      rsp_replay,
   output logic                      prefetch_stall
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PFN_W = PA_W - PAGE_BITS;

   if (PAGE_BITS < 1 || VPN_W < 1 || PFN_W < 1) begin : g_bad_geometry
      $error("io_read_guard: page offset must be narrower than both addresses");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("io_read_guard: DATA_W must be positive");
   end

   logic             lk_hit;
   logic [PFN_W-1:0] lk_pfn;
   logic [PA_W-1:0]  lk_paddr;

   iorg_xlate_buf #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W)
   ) u_xlate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tlb_wr_en),
      .wr_vpn   (tlb_wr_vpn),
      .wr_pfn   (tlb_wr_pfn),
      .wr_valid (tlb_wr_valid),
      .lk_vpn   (req_vaddr[VA_W-1:PAGE_BITS]),
      .lk_hit   (lk_hit),
      .lk_pfn   (lk_pfn)
   );

   assign lk_paddr = {lk_pfn, req_vaddr[PAGE_BITS-1:0]};

   iorg_seq #(
      .PA_W   (PA_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_nonspec    (req_nonspec),
      .older_pending  (older_pending),
      .flush          (flush),
      .lk_hit         (lk_hit),
      .lk_paddr       (lk_paddr),
      .req_ready      (req_ready),
      .bus_valid      (bus_valid),
      .bus_paddr      (bus_paddr),
      .bus_is_io      (bus_is_io),
      .bus_ready      (bus_ready),
      .bus_rvalid     (bus_rvalid),
      .bus_rdata      (bus_rdata),
      .rsp_done       (rsp_done),
      .rsp_data       (rsp_data),
      .rsp_miss       (rsp_miss),
      .rsp_replay     (rsp_replay),
      .prefetch_stall (prefetch_stall)
   );

   p_io_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_is_io == bus_paddr[PA_W-1]));

   p_replay_needs_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lk_hit && !lk_paddr[PA_W-1]) |=> !rsp_replay);

endmodule

// File: tb/io_read_guard_bench.sv
module io_read_guard_bench;
   localparam int VA_W = 32, PA_W = 30, PAGE_BITS = 9, ENTRIES = 8, DATA_W = 32;
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PFN_W = PA_W - PAGE_BITS;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_nonspec = 0, older_pending = 0, flush = 0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic tlb_wr_en = 0, tlb_wr_valid = 0;
   logic [VPN_W-1:0] tlb_wr_vpn = '0;
   logic [PFN_W-1:0] tlb_wr_pfn = '0;
   logic bus_ready = 0, bus_rvalid = 0;
   logic [DATA_W-1:0] bus_rdata = '0;
   logic req_ready, bus_valid, bus_is_io, rsp_done, rsp_miss, rsp_replay, prefetch_stall;
   logic [PA_W-1:0] bus_paddr;
   logic [DATA_W-1:0] rsp_data;

   int checks = 0, errors = 0, cyc = 0;
   int issue_cnt = 0, miss_cnt = 0, replay_cnt = 0;
   logic [DATA_W-1:0] last_data = '0;

   // reference model state
   int m_state = 0;
   bit m_stall = 0, m_io = 0, m_done = 0, m_miss = 0, m_replay = 0, m_acc = 0, started = 0;
   logic [PA_W-1:0] m_paddr = '0;
   logic [DATA_W-1:0] m_data = '0;
   bit m_vld [ENTRIES];
   logic [VPN_W-1:0] m_vpn [ENTRIES];
   logic [PFN_W-1:0] m_pfn [ENTRIES];
   int m_ptr = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit fast_bus = 0;

   always #4 clk = ~clk;

   io_read_guard #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
                   .ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_io_read_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_nonspec(req_nonspec), .older_pending(older_pending),
      .flush(flush), .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn),
      .tlb_wr_pfn(tlb_wr_pfn), .tlb_wr_valid(tlb_wr_valid), .bus_valid(bus_valid),
      .bus_ready(bus_ready), .bus_paddr(bus_paddr), .bus_is_io(bus_is_io),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .rsp_done(rsp_done),
      .rsp_data(rsp_data), .rsp_miss(rsp_miss), .rsp_replay(rsp_replay),
      .prefetch_stall(prefetch_stall));

   function automatic logic [DATA_W-1:0] data_of(input logic [PA_W-1:0] pa);
      return {2'b10, pa} ^ 32'h0F0F_3C3C;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_state = 0; m_stall = 0; m_io = 0; m_paddr = '0; m_data = '0;
         m_done = 0; m_miss = 0; m_replay = 0; m_acc = 0; m_ptr = 0;
         foreach (m_vld[i]) begin m_vld[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; end
         started = 1;
      end else begin
         bit ready_now, hit;
         logic [PA_W-1:0] pa;
         ready_now = (m_state == 0) && !flush && (!m_stall || req_nonspec);
         m_acc = req_valid && ready_now;
         hit = 0; pa = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && m_vld[i] && m_vpn[i] == req_vaddr[VA_W-1:PAGE_BITS]) begin
               hit = 1;
               pa = {m_pfn[i], req_vaddr[PAGE_BITS-1:0]};
            end
         end
         m_done = 0; m_miss = 0; m_replay = 0;
         if (flush) m_stall = 0;
         case (m_state)
            0: if (m_acc) begin
                  if (!hit) m_miss = 1;
                  else if (pa[PA_W-1] && !req_nonspec && older_pending) begin
                     m_replay = 1; m_stall = 1;
                  end else begin
                     m_state = 1; m_paddr = pa; m_io = pa[PA_W-1];
                  end
               end
            1: if (bus_ready) m_state = 2;
            default: if (bus_rvalid) begin
                  m_done = 1; m_data = bus_rdata; m_state = 0;
                  if (m_io) m_stall = 0;
               end
         endcase
         if (tlb_wr_en) begin
            m_vld[m_ptr] = tlb_wr_valid; m_vpn[m_ptr] = tlb_wr_vpn; m_pfn[m_ptr] = tlb_wr_pfn;
            m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
         end
      end
      if (rst_n) begin
         if (bus_valid && bus_ready) issue_cnt++;
         if (rsp_miss) miss_cnt++;
         if (rsp_replay) replay_cnt++;
         if (rsp_done) last_data = rsp_data;
      end
      if (cyc > LIMIT) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<=%0d cycles", cyc, LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // bus responder
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_ready = fast_bus ? 1'b1 : lfsr[0];
      bus_rvalid = (m_state == 2) && (fast_bus || lfsr[3]);
      bus_rdata = bus_rvalid ? data_of(m_paddr) : {lfsr, lfsr};
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (started) begin
         bit er;
         er = (m_state == 0) && !flush && (!m_stall || req_nonspec);
         chk(req_ready == er, "R3 req_ready", 64'(req_ready), 64'(er));
         chk(bus_valid == (m_state == 1), "R6 bus_valid", 64'(bus_valid), 64'(m_state == 1));
         if (m_state == 1) begin
            chk(bus_paddr == m_paddr, "R1 bus_paddr", 64'(bus_paddr), 64'(m_paddr));
            chk(bus_is_io == m_paddr[PA_W-1], "R2 bus_is_io", 64'(bus_is_io), 64'(m_paddr[PA_W-1]));
         end
         chk(rsp_miss == m_miss, "R7 R11 rsp_miss", 64'(rsp_miss), 64'(m_miss));
         chk(rsp_replay == m_replay, "R4 rsp_replay", 64'(rsp_replay), 64'(m_replay));
         chk(prefetch_stall == m_stall, "R5 R8 R10 prefetch_stall", 64'(prefetch_stall), 64'(m_stall));
         chk(rsp_done == m_done, "R9 rsp_done", 64'(rsp_done), 64'(m_done));
         if (m_done) chk(rsp_data == m_data, "R9 rsp_data", 64'(rsp_data), 64'(m_data));
      end
   end

   task automatic tlb_put(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn, input bit v);
      @(negedge clk);
      tlb_wr_en = 1; tlb_wr_vpn = vpn; tlb_wr_pfn = pfn; tlb_wr_valid = v;
      @(negedge clk);
      tlb_wr_en = 0;
   endtask

   task automatic send(input logic [VPN_W-1:0] vpn, input logic [PAGE_BITS-1:0] off,
                       input bit nonspec, input bit older);
      @(negedge clk);
      req_valid = 1; req_vaddr = {vpn, off}; req_nonspec = nonspec; older_pending = older;
      do @(negedge clk); while (!m_acc);
      req_valid = 0; req_nonspec = 0;
   endtask

   task automatic settle();
      while (m_state != 0) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      flush = 1;
      @(negedge clk);
      flush = 0;
   endtask

   localparam logic [PFN_W-1:0] MEM_A = 21'h000123, IO_B = 21'h100005;
   localparam logic [PFN_W-1:0] MEM_C = 21'h000777, IO_D = 21'h1000AA;

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #3;
      chk(req_ready == 1, "R3 reset ready", 64'(req_ready), 64'd1);
      chk(prefetch_stall == 0 && bus_valid == 0, "R5 reset idle", 64'({prefetch_stall, bus_valid}), 64'd0);

      tlb_put(23'h10, MEM_A, 1);
      tlb_put(23'h20, IO_B, 1);
      tlb_put(23'h30, MEM_C, 1);
      tlb_put(23'h40, IO_D, 1);

      // memory read with older work pending goes out at once
      send(23'h10, 9'h1F4, 0, 1);
      settle();
      chk(last_data == data_of({MEM_A, 9'h1F4}), "R6 R1 memory read data", 64'(last_data), 64'(data_of({MEM_A, 9'h1F4})));

      // miss
      n = miss_cnt;
      send(23'h99, 9'h0, 0, 0);
      settle();
      chk(miss_cnt == n + 1, "R7 miss pulse", 64'(miss_cnt), 64'(n + 1));

      // speculative I/O read dropped
      n = issue_cnt;
      send(23'h20, 9'h044, 0, 1);
      settle();
      chk(issue_cnt == n, "R4 dropped read not on bus", 64'(issue_cnt), 64'(n));
      chk(prefetch_stall == 1, "R4 freeze set", 64'(prefetch_stall), 64'd1);

      // speculative requests held off while frozen
      @(negedge clk);
      req_valid = 1; req_vaddr = {23'h30, 9'h8}; req_nonspec = 0; older_pending = 0;
      repeat (6) @(negedge clk);
      #1;
      chk(m_acc == 0 && req_ready == 0, "R5 speculative held off", 64'(req_ready), 64'd0);
      req_valid = 0;

      // replay as non-speculative
      send(23'h20, 9'h044, 1, 1);
      settle();
      chk(prefetch_stall == 0, "R8 freeze released", 64'(prefetch_stall), 64'd0);
      chk(last_data == data_of({IO_B, 9'h044}), "R8 R2 io data", 64'(last_data), 64'(data_of({IO_B, 9'h044})));

      // drop then flush
      send(23'h40, 9'h1, 0, 1);
      settle();
      n = issue_cnt;
      pulse_flush();
      settle();
      chk(prefetch_stall == 0, "R10 flush clears freeze", 64'(prefetch_stall), 64'd0);
      chk(issue_cnt == n, "R10 flush issues nothing", 64'(issue_cnt), 64'(n));

      // I/O read with nothing older pending runs directly
      send(23'h40, 9'h2, 0, 0);
      settle();
      chk(last_data == data_of({IO_D, 9'h2}), "R6 oldest io read", 64'(last_data), 64'(data_of({IO_D, 9'h2})));

      // round-robin wrap: slots 4..7, then slot 0 replaced
      for (int i = 0; i < 4; i++) tlb_put(23'h50 + 23'(i), 21'h000200 + 21'(i), 1);
      tlb_put(23'h60, 21'h000333, 1);
      n = miss_cnt;
      send(23'h10, 9'h0, 0, 0);
      settle();
      chk(miss_cnt == n + 1, "R11 overwritten slot misses", 64'(miss_cnt), 64'(n + 1));
      tlb_put(23'h20, IO_B, 0);
      n = miss_cnt;
      send(23'h20, 9'h0, 1, 0);
      settle();
      chk(miss_cnt == n + 1, "R11 invalidated slot misses", 64'(miss_cnt), 64'(n + 1));
      // slot 2 now shadows slot 3 for the same page
      tlb_put(23'h40, 21'h000444, 1);
      send(23'h40, 9'h3, 0, 1);
      settle();
      chk(last_data == data_of({21'h000444, 9'h3}), "R1 lowest slot wins", 64'(last_data), 64'(data_of({21'h000444, 9'h3})));

      // random phase
      for (int k = 0; k < 600; k++) begin
         int r;
         logic [VPN_W-1:0] v;
         r = $urandom_range(0, 11);
         fast_bus = ($urandom_range(0, 3) == 0);
         if (r == 0) pulse_flush();
         else begin
            case ($urandom_range(0, 5))
               0: v = 23'h30; 1: v = 23'h40; 2: v = 23'h50;
               3: v = 23'h51; 4: v = 23'h60; default: v = 23'h77;
            endcase
            if (r == 1) tlb_put(v, 21'($urandom), 1);
            send(v, 9'($urandom), m_stall ? 1'b1 : ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1);
            older_pending = $urandom_range(0, 1) == 1;
            repeat ($urandom_range(0, 3)) @(negedge clk);
         end
      end
      settle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule